// File: doc/BRIEF.md
# Push-Button Power State Controller

This block decides whether a battery- or bus-powered reader has its main supply enabled, from one momentary switch that pulls its input to ground. Each accepted press flips the power state: a press while off turns power on, and a press while on asks the host for permission to turn off. Power is removed only when the host answers that request. The host may also end the on state by itself, by raising its acknowledge line without any press.

When bus power is present the block holds power on. It ignores the button and the host acknowledge for as long as bus power stays. If bus power arrives while a request is pending, the request is withdrawn. The button, bus-power and acknowledge inputs are asynchronous and are synchronised inside the block. The button is also debounced over a parameterised number of clock cycles. The default is 1,000,000 cycles, which is 20 ms at 50 MHz.

Top module: `pwr_button_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, `pwr_en` and `off_req` are both 0 and the block is in the off state.
- R2: In the off state, a button press (`btn_n` = 0) that stays low for at least `DEBOUNCE_CYCLES` cycles sets `pwr_en` to 1 and leaves `off_req` at 0.
- R3: A low pulse on `btn_n` shorter than `DEBOUNCE_CYCLES` cycles changes neither output, in any state.
- R4: In the on state, an accepted press sets `off_req` to 1 while `pwr_en` stays 1. `off_req` is never 1 while `pwr_en` is 0.
- R5: Once raised, `off_req` stays 1 until `off_ack` = 1 is seen, and further presses have no effect on it. On the acknowledge, both `pwr_en` and `off_req` drop to 0.
- R6: After a shutdown the block leaves the shutdown state only once `off_ack` returns to 0. Presses made while `off_ack` is still 1 are ignored. After `off_ack` falls, the next press turns power on.
- R7: In the on state, `off_ack` = 1 without a press turns `pwr_en` off directly, and `off_req` stays 0 throughout.
- R8: In the off state, `off_ack` has no effect on either output.
- R9: While `bus_pwr` = 1 the block is in the on state from any prior state, with `pwr_en` = 1 and `off_req` = 0. Presses and `off_ack` are ignored. When `bus_pwr` falls the block stays in the on state.
- R10: If `bus_pwr` rises while `off_req` = 1, the request is withdrawn (`off_req` = 0) and `pwr_en` stays 1.
- R11: Holding the button low continuously counts as one press only. A further press is accepted only after the input has been stably high for `DEBOUNCE_CYCLES` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| btn_n | input | 1 | Momentary switch, low while pressed, asynchronous |
| bus_pwr | input | 1 | Bus power present, asynchronous |
| off_ack | input | 1 | Host acknowledge / host power-off command, asynchronous |
| pwr_en | output | 1 | Main power enable |
| off_req | output | 1 | Power-off request to the host |

## Verification
The bench drives short low glitches in the off and on states. A debouncer that acted on raw edges would toggle power on each of them. It holds the button down for several debounce windows, where an auto-repeating design would fall straight into a second request. It presses again while a request is pending and while the acknowledge is still high after shutdown, to expose designs that drop the request or that re-enable power before the host releases its line. It raises bus power during a pending request and during shutdown, and removes it while the acknowledge is still high. A design without a full bus override would leave the request standing or would keep power off there.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_ON   = 2'd1,
    PS_REQ  = 2'd2,
    PS_SHUT = 2'd3
  } pwr_state_e;

endpackage

// File: rtl/pbc_sync.sv
module pbc_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= RST_VAL;
        else        stg_q[0] <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= {STAGES{RST_VAL}};
        else        stg_q <= {stg_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pbc_debounce.sv
module pbc_debounce #(
  parameter int CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,        // synchronised, 1 = pressed
  output logic press_evt   // one-cycle pulse on accepted press
);

  localparam int            CW    = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          level_q, level_d;
  logic          evt_q, evt_d;
  logic          differ;
  logic          cnt_en;

  assign differ = raw ^ level_q;
  assign cnt_en = differ || (cnt_q != '0);

  always_comb begin
    cnt_d   = cnt_q;
    level_d = level_q;
    evt_d   = 1'b0;
    if (!differ) begin
      cnt_d = '0;
    end else if (cnt_q == LIMIT) begin
      cnt_d   = '0;
      level_d = raw;
      evt_d   = raw;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      level_q <= level_d;
      evt_q   <= evt_d;
    end
  end

  assign press_evt = evt_q;

  // R11: an accepted press is a single pulse, never a held level
  p_evt_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    press_evt |=> !press_evt);

  // R3: the debounced level only moves after a full window of disagreement
  p_level_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_q) |-> $past(cnt_q == LIMIT));

  // R11: a press event requires the debounced level to have just become pressed
  p_evt_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    press_evt |-> (level_q && !$past(level_q)));

endmodule

// File: rtl/pbc_fsm.sv
module pbc_fsm
  import pbc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic press_evt,
  input  logic bus_s,
  input  logic ack_s,
  output logic pwr_en,
  output logic off_req
);

  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (bus_s) begin
      state_d = PS_ON;
    end else begin
      unique case (state_q)
        PS_OFF:  if (press_evt) state_d = PS_ON;
        PS_ON: begin
          if (ack_s)          state_d = PS_SHUT;
          else if (press_evt) state_d = PS_REQ;
        end
        PS_REQ:  if (ack_s)  state_d = PS_SHUT;
        PS_SHUT: if (!ack_s) state_d = PS_OFF;
        default:             state_d = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_OFF;
    else        state_q <= state_d;
  end

  assign pwr_en  = (state_q == PS_ON) || (state_q == PS_REQ);
  assign off_req = (state_q == PS_REQ);

  // R4: a request is only ever raised while power is on
  p_req_needs_pwr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    off_req |-> pwr_en);

  // R5: the request holds until acknowledged or overridden by bus power
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (off_req && !ack_s && !bus_s) |=> off_req);

  // R5 / R7: power is removed only in response to the acknowledge
  p_fall_on_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(ack_s && !bus_s));

  // R2 / R9: power comes on only after a press or bus power
  p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> $past(press_evt || bus_s));

  // R9: bus power forces the on state with no request
  p_bus_on_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_s |=> (pwr_en && !off_req));

  // R6: shutdown persists while the acknowledge is still high
  p_shut_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PS_SHUT && ack_s && !bus_s) |=> (state_q == PS_SHUT));

endmodule

// File: rtl/pwr_button_ctrl.sv
module pwr_button_ctrl #(
  parameter int DEBOUNCE_CYCLES = 1000000,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_n,
  input  logic bus_pwr,
  input  logic off_ack,
  output logic pwr_en,
  output logic off_req
);

  localparam int NUM_IN = 3;

  logic              rst_n_s;
  logic [NUM_IN-1:0] in_s;
  logic              press_evt;

  pbc_sync #(
    .WIDTH  (1),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b0)
  ) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (1'b1),
    .q    (rst_n_s)
  );

  pbc_sync #(
    .WIDTH  (NUM_IN),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_in_sync (
    .clk  (clk),
    .rst_n(rst_n_s),
    .d    ({btn_n, bus_pwr, off_ack}),
    .q    (in_s)
  );

  pbc_debounce #(
    .CYCLES(DEBOUNCE_CYCLES)
  ) u_debounce (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .raw      (~in_s[2]),
    .press_evt(press_evt)
  );

  pbc_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .press_evt(press_evt),
    .bus_s    (in_s[1]),
    .ack_s    (in_s[0]),
    .pwr_en   (pwr_en),
    .off_req  (off_req)
  );

  // R1: outputs are quiet while reset is applied
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n_s |-> (!pwr_en && !off_req));

endmodule

// File: tb/pwr_button_ctrl_bench.sv
module pwr_button_ctrl_bench;

  localparam int DEB  = 8;
  localparam int SETL = DEB + 8;

  localparam logic [3:0] A_PRESS  = 4'd0;
  localparam logic [3:0] A_GLITCH = 4'd1;
  localparam logic [3:0] A_ACK1   = 4'd2;
  localparam logic [3:0] A_ACK0   = 4'd3;
  localparam logic [3:0] A_BUS1   = 4'd4;
  localparam logic [3:0] A_BUS0   = 4'd5;
  localparam logic [3:0] A_LONG   = 4'd6;

  localparam int NV = 25;
  // {requirement, action, expected pwr_en, expected off_req}
  localparam logic [9:0] VEC [NV] = '{
    {4'd3,  A_GLITCH, 2'b00},  // R3 glitch while off
    {4'd8,  A_ACK1,   2'b00},  // R8 ack ignored while off
    {4'd8,  A_ACK0,   2'b00},  // R8
    {4'd2,  A_PRESS,  2'b10},  // R2 press turns on
    {4'd3,  A_GLITCH, 2'b10},  // R3 glitch while on
    {4'd4,  A_PRESS,  2'b11},  // R4 request raised
    {4'd5,  A_PRESS,  2'b11},  // R5 press while requesting ignored
    {4'd5,  A_ACK1,   2'b00},  // R5 ack removes power
    {4'd6,  A_PRESS,  2'b00},  // R6 press during shutdown ignored
    {4'd6,  A_ACK0,   2'b00},  // R6 back to off
    {4'd6,  A_PRESS,  2'b10},  // R6 next press turns on
    {4'd7,  A_ACK1,   2'b00},  // R7 host-initiated off
    {4'd7,  A_ACK0,   2'b00},  // R7
    {4'd11, A_LONG,   2'b10},  // R11 long hold is one press
    {4'd4,  A_PRESS,  2'b11},  // R4
    {4'd10, A_BUS1,   2'b10},  // R10 bus withdraws request
    {4'd9,  A_PRESS,  2'b10},  // R9 press ignored under bus
    {4'd9,  A_ACK1,   2'b10},  // R9 ack ignored under bus
    {4'd9,  A_ACK0,   2'b10},  // R9
    {4'd9,  A_BUS0,   2'b10},  // R9 stays on after bus leaves
    {4'd4,  A_PRESS,  2'b11},  // R4
    {4'd5,  A_ACK1,   2'b00},  // R5
    {4'd9,  A_BUS1,   2'b10},  // R9 bus overrides shutdown
    {4'd7,  A_BUS0,   2'b00},  // R7 ack still high once bus leaves
    {4'd7,  A_ACK0,   2'b00}   // R7
  };

  logic clk = 1'b0;
  logic rst_n;
  logic btn_n, bus_pwr, off_ack;
  logic pwr_en, off_req;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pwr_button_ctrl #(
    .DEBOUNCE_CYCLES(DEB),
    .SYNC_STAGES    (2)
  ) u_pwr_button_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .btn_n  (btn_n),
    .bus_pwr(bus_pwr),
    .off_ack(off_ack),
    .pwr_en (pwr_en),
    .off_req(off_req)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input int rq, input logic ep, input logic er);
    tests++;
    if (pwr_en !== ep || off_req !== er) begin
      fails++;
      $display("FAIL R%0d: pwr_en=%b off_req=%b, expected pwr_en=%b off_req=%b",
               rq, pwr_en, off_req, ep, er);
    end
  endtask

  task automatic apply(input logic [3:0] act);
    case (act)
      A_PRESS:  begin btn_n = 1'b0; wait_cyc(SETL); btn_n = 1'b1; wait_cyc(SETL); end
      A_GLITCH: begin btn_n = 1'b0; wait_cyc(DEB / 2); btn_n = 1'b1; wait_cyc(SETL); end
      A_LONG:   begin btn_n = 1'b0; wait_cyc(5 * DEB); btn_n = 1'b1; wait_cyc(SETL); end
      A_ACK1:   begin off_ack = 1'b1; wait_cyc(6); end
      A_ACK0:   begin off_ack = 1'b0; wait_cyc(6); end
      A_BUS1:   begin bus_pwr = 1'b1; wait_cyc(6); end
      A_BUS0:   begin bus_pwr = 1'b0; wait_cyc(6); end
      default:  wait_cyc(1);
    endcase
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_cyc(4);
    check(1, 1'b0, 1'b0);   // R1 during reset
    rst_n = 1'b1;
    wait_cyc(4);
    check(1, 1'b0, 1'b0);   // R1 after release
  endtask

  initial begin
    btn_n = 1'b1; bus_pwr = 1'b0; off_ack = 1'b0; rst_n = 1'b0;
    wait_cyc(2);
    do_reset();

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][5:2]);
      check(int'(VEC[i][9:6]), VEC[i][1], VEC[i][0]);
    end

    // R1: reset from the on state returns to off
    apply(A_PRESS);
    check(2, 1'b1, 1'b0);
    do_reset();

    // R9: bus power alone turns the block on from off
    apply(A_BUS1);
    check(9, 1'b1, 1'b0);
    apply(A_BUS0);
    check(9, 1'b1, 1'b0);

    // R7: off_req must stay low through a host-initiated shutdown
    off_ack = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (off_req !== 1'b0) begin
        tests++; fails++;
        $display("FAIL R7: off_req=%b during host shutdown, expected 0", off_req);
      end
    end
    check(7, 1'b0, 1'b0);
    apply(A_ACK0);

    // R11: while held, the block must not reach the request state
    btn_n = 1'b0;
    wait_cyc(SETL);
    check(11, 1'b1, 1'b0);
    wait_cyc(4 * DEB);
    check(11, 1'b1, 1'b0);
    btn_n = 1'b1;
    wait_cyc(SETL);
    // R3 / R11: bounce on release must not register a new press
    btn_n = 1'b0; wait_cyc(2); btn_n = 1'b1; wait_cyc(2);
    btn_n = 1'b0; wait_cyc(2); btn_n = 1'b1; wait_cyc(SETL);
    check(3, 1'b1, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule